// File: doc/BRIEF.md
# Change-Tracking Output Register Bank

This block sits between a device under test and a host bus inside a hardware-in-the-loop wrapper. Every device input gets a host-writable register that drives the device directly. Every device output gets a capture register that samples the device on each clock. Each capture register has a change detector and a sticky "unread" flag. The flags are packed into bus-width status words.

In each simulation step the host reads the status words first. It then fetches only those output registers whose flag is set. A full sweep therefore costs the number of changed outputs plus ceil(outputs / bus width) status reads, instead of one read per output.

The host side is a plain memory-mapped strobe interface:
- A read strobe returns data one cycle later, marked by `host_rvalid`.
- A write strobe takes effect at the clock edge.
- There is no back-pressure: every strobe is accepted in the cycle it is presented, so no ready signal exists.
- Device-side ports are continuous register connections with no handshake.

The address map has three regions in this order:
- input registers, starting at 0;
- output data registers, starting at N_IN;
- status words, starting at N_IN+N_OUT.

Top module: `chg_track_regbank`

## Requirements
- R1: While `rst` is high, and after it falls with the device outputs at zero: every input register, capture register and flag holds zero, `host_rdata` is 0 and `host_rvalid` is 0.
- R2: A write to address j < N_IN loads `host_wdata[PORT_W-1:0]` into input register j, which appears on `dut_in[j*PORT_W +: PORT_W]` after that clock edge.
- R3: A read of address j < N_IN returns input register j, zero-extended to BUS_W bits.
- R4: Each output port is sampled on every clock. A read of address N_IN+p returns the value port p had been sampled to before the edge on which the read is taken, zero-extended.
- R5: On any edge where port p's incoming value differs from its stored value, the flag for p becomes 1.
- R6: A flag stays 1 until output data address N_IN+p is read. That read clears it, and reading the other address regions leaves it alone.
- R7: If port p changes on the same edge as a read of N_IN+p, the flag ends up 1.
- R8: Status word k (address N_IN+N_OUT+k) carries the flag of port k*BUS_W+i in bit i. Bits beyond the last port read as 0.
- R9: Writes to output data or status addresses change no input register, no captured value and no flag.
- R10: A read strobe is answered with `host_rvalid`=1 in the next cycle only. Addresses at or beyond N_IN+N_OUT+ceil(N_OUT/BUS_W) read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe |
| host_rd_en | input | 1 | Host read strobe |
| host_addr | input | ADDR_W | Host word address |
| host_wdata | input | BUS_W | Host write data |
| host_rdata | output | BUS_W | Read data, registered |
| host_rvalid | output | 1 | High for one cycle after a read strobe |
| dut_in | output | N_IN*PORT_W | Input registers driving the device |
| dut_out | input | N_OUT*PORT_W | Device outputs, sampled each clock |

## Verification
The bench targets the edge where a port changes while its own data register is being read. A design that lets the clear win would lose that update, and the following status read would show bit 0 where 1 is expected.

It also checks:
- **Status bit placement.** Status bits are checked for ports in the second status word. An indexing slip would show the flag in the wrong word or bit, or leave junk in the unused upper bits.
- **Stray writes and cross-region reads.** Writes aimed at output and status addresses must not change any state, and reads of other regions must not clear flags.
- **Read-back timing.** Data reads must return the value from before the edge, so an off-by-one capture would return the newer value.

A long random phase repeats the status-then-fetch sweep against a model.

// File: rtl/chg_pkg.sv
package chg_pkg;
  typedef enum logic [1:0] {RG_IN, RG_OUT, RG_STAT, RG_NONE} reg_region_e;

  function automatic int div_ceil(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
endpackage

// File: rtl/chg_out_cell.sv
module chg_out_cell #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  input  logic         clr,
  output logic [W-1:0] q,
  output logic         flag
);
  logic diff;
  assign diff = (d_in != q);

  always_ff @(posedge clk) begin
    if (rst) begin
      q    <= '0;
      flag <= 1'b0;
    end else begin
      q <= d_in;
      if (diff)     flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end

  assert_flag_set_R5: assert property (@(posedge clk) disable iff (rst)
    (d_in != q) |=> flag);
  assert_flag_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);
  assert_flag_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (clr && d_in == q) |=> !flag);
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (clr && d_in != q) |=> flag);
endmodule

// File: rtl/chg_in_bank.sv
module chg_in_bank
  import chg_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int PORT_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  reg_region_e              region,
  input  int                       idx,
  input  logic [PORT_W-1:0]        wdata,
  output logic [N_IN*PORT_W-1:0]   q_flat
);
  for (genvar j = 0; j < N_IN; j++) begin : g_in
    always_ff @(posedge clk) begin
      if (rst)
        q_flat[j*PORT_W +: PORT_W] <= '0;
      else if (wr_en && region == RG_IN && idx == j)
        q_flat[j*PORT_W +: PORT_W] <= wdata;
    end
  end

  assert_stray_write_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && region != RG_IN) |=> $stable(q_flat));
endmodule

// File: rtl/chg_read_mux.sv
module chg_read_mux
  import chg_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int N_OUT  = 20,
  parameter int PORT_W = 8,
  parameter int BUS_W  = 16,
  localparam int N_STAT = div_ceil(N_OUT, BUS_W)
) (
  input  reg_region_e               region,
  input  int                        idx,
  input  logic [N_IN*PORT_W-1:0]    in_q,
  input  logic [N_OUT*PORT_W-1:0]   out_q,
  input  logic [N_OUT-1:0]          flags,
  output logic [BUS_W-1:0]          word
);
  logic [N_STAT*BUS_W-1:0] flag_pad;

  always_comb begin
    flag_pad = '0;
    flag_pad[N_OUT-1:0] = flags;
  end

  always_comb begin
    word = '0;
    unique case (region)
      RG_IN:
        for (int j = 0; j < N_IN; j++)
          if (idx == j) word[PORT_W-1:0] = in_q[j*PORT_W +: PORT_W];
      RG_OUT:
        for (int p = 0; p < N_OUT; p++)
          if (idx == p) word[PORT_W-1:0] = out_q[p*PORT_W +: PORT_W];
      RG_STAT:
        for (int k = 0; k < N_STAT; k++)
          if (idx == k) word = flag_pad[k*BUS_W +: BUS_W];
      default: word = '0;
    endcase
  end
endmodule

// File: rtl/chg_track_regbank.sv
module chg_track_regbank
  import chg_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int N_OUT  = 20,
  parameter int PORT_W = 12,
  parameter int BUS_W  = 16,
  localparam int N_STAT = div_ceil(N_OUT, BUS_W),
  localparam int N_TOT  = N_IN + N_OUT + N_STAT,
  localparam int ADDR_W = (N_TOT > 2) ? $clog2(N_TOT) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    host_wr_en,
  input  logic                    host_rd_en,
  input  logic [ADDR_W-1:0]       host_addr,
  input  logic [BUS_W-1:0]        host_wdata,
  output logic [BUS_W-1:0]        host_rdata,
  output logic                    host_rvalid,
  output logic [N_IN*PORT_W-1:0]  dut_in,
  input  logic [N_OUT*PORT_W-1:0] dut_out
);
  localparam int LAST_BITS = N_OUT - (N_STAT - 1) * BUS_W;

  reg_region_e             region;
  int                      idx;
  int                      a_int;
  logic [N_OUT*PORT_W-1:0] out_q;
  logic [N_OUT-1:0]        flags;
  logic [N_OUT-1:0]        clr;
  logic [BUS_W-1:0]        rd_word;

  // Address decode into region and index within region.
  always_comb begin
    a_int = int'(host_addr);
    if (a_int < N_IN) begin
      region = RG_IN;
      idx    = a_int;
    end else if (a_int < N_IN + N_OUT) begin
      region = RG_OUT;
      idx    = a_int - N_IN;
    end else if (a_int < N_TOT) begin
      region = RG_STAT;
      idx    = a_int - N_IN - N_OUT;
    end else begin
      region = RG_NONE;
      idx    = 0;
    end
  end

  if (PORT_W < BUS_W) begin : g_wide_bus
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^host_wdata[BUS_W-1:PORT_W];
  end

  chg_in_bank #(.N_IN(N_IN), .PORT_W(PORT_W)) u_in (
    .clk(clk), .rst(rst), .wr_en(host_wr_en), .region(region), .idx(idx),
    .wdata(host_wdata[PORT_W-1:0]), .q_flat(dut_in)
  );

  for (genvar p = 0; p < N_OUT; p++) begin : g_out
    assign clr[p] = host_rd_en && (region == RG_OUT) && (idx == p);
    chg_out_cell #(.W(PORT_W)) u_cell (
      .clk(clk), .rst(rst),
      .d_in(dut_out[p*PORT_W +: PORT_W]),
      .clr(clr[p]),
      .q(out_q[p*PORT_W +: PORT_W]),
      .flag(flags[p])
    );
  end

  chg_read_mux #(.N_IN(N_IN), .N_OUT(N_OUT), .PORT_W(PORT_W), .BUS_W(BUS_W)) u_mux (
    .region(region), .idx(idx), .in_q(dut_in), .out_q(out_q),
    .flags(flags), .word(rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= host_rd_en;
      if (host_rd_en) host_rdata <= rd_word;
    end
  end

  assert_rvalid_R10: assert property (@(posedge clk) disable iff (rst)
    host_rd_en |=> host_rvalid);
  assert_rvalid_once_R10: assert property (@(posedge clk) disable iff (rst)
    !host_rd_en |=> !host_rvalid);
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (host_rd_en && int'(host_addr) >= N_TOT) |=> host_rdata == '0);
  assert_pad_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (host_rd_en && int'(host_addr) == N_TOT - 1) |=> (host_rdata >> LAST_BITS) == '0);
  assert_clear_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(clr));
endmodule

// File: tb/chg_track_regbank_test.sv
`timescale 1ns/1ps
module chg_track_regbank_test;
  localparam int N_IN = 4, N_OUT = 20, PORT_W = 12, BUS_W = 16;
  localparam int N_STAT = (N_OUT + BUS_W - 1) / BUS_W;
  localparam int N_TOT = N_IN + N_OUT + N_STAT;
  localparam int ADDR_W = $clog2(N_TOT);
  localparam int OBASE = N_IN, SBASE = N_IN + N_OUT;

  logic clk = 0, rst = 1, wr_en = 0, rd_en = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [BUS_W-1:0] wdata = '0, rdata;
  logic rvalid;
  logic [N_IN*PORT_W-1:0] dut_in;
  logic [N_OUT*PORT_W-1:0] dut_out = '0;

  logic [PORT_W-1:0] exp_q [N_OUT];
  bit                exp_flag [N_OUT];
  logic [PORT_W-1:0] exp_in [N_IN];
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  chg_track_regbank #(.N_IN(N_IN), .N_OUT(N_OUT), .PORT_W(PORT_W), .BUS_W(BUS_W)) uut (
    .clk(clk), .rst(rst), .host_wr_en(wr_en), .host_rd_en(rd_en), .host_addr(addr),
    .host_wdata(wdata), .host_rdata(rdata), .host_rvalid(rvalid),
    .dut_in(dut_in), .dut_out(dut_out)
  );

  task automatic chk(input string tag, input logic [BUS_W-1:0] act, input logic [BUS_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [BUS_W-1:0] model_read(input int a);
    logic [BUS_W-1:0] w = '0;
    if (a < N_IN) w[PORT_W-1:0] = exp_in[a];
    else if (a < SBASE) w[PORT_W-1:0] = exp_q[a - OBASE];
    else if (a < N_TOT)
      for (int i = 0; i < BUS_W; i++)
        if ((a - SBASE) * BUS_W + i < N_OUT) w[i] = exp_flag[(a - SBASE) * BUS_W + i];
    return w;
  endfunction

  // Advance one clock, updating the model with the values driven before the edge.
  task automatic tick(output logic [BUS_W-1:0] exp_rd);
    int a = int'(addr);
    exp_rd = model_read(a);
    for (int p = 0; p < N_OUT; p++) begin
      logic [PORT_W-1:0] nv = dut_out[p*PORT_W +: PORT_W];
      if (nv != exp_q[p]) exp_flag[p] = 1;
      else if (rd_en && a == OBASE + p) exp_flag[p] = 0;
      exp_q[p] = nv;
    end
    if (wr_en && a < N_IN) exp_in[a] = wdata[PORT_W-1:0];
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    logic [BUS_W-1:0] e;
    tick(e);
  endtask

  task automatic rd(input int a, input string tag);
    logic [BUS_W-1:0] e;
    rd_en = 1; addr = ADDR_W'(a);
    tick(e);
    rd_en = 0;
    chk({tag, " rvalid R10"}, {{(BUS_W-1){1'b0}}, rvalid}, 1);
    chk(tag, rdata, e);
  endtask

  task automatic wr(input int a, input logic [BUS_W-1:0] d);
    logic [BUS_W-1:0] e;
    wr_en = 1; addr = ADDR_W'(a); wdata = d;
    tick(e);
    wr_en = 0;
  endtask

  task automatic set_out(input int p, input logic [PORT_W-1:0] v);
    dut_out[p*PORT_W +: PORT_W] = v;
  endtask

  task automatic t_reset();
    for (int p = 0; p < N_OUT; p++) begin exp_q[p] = '0; exp_flag[p] = 0; end
    for (int j = 0; j < N_IN; j++) exp_in[j] = '0;
    rst = 1;
    repeat (3) @(negedge clk);
    chk("R1 rdata", rdata, 0);
    chk("R1 rvalid", {{(BUS_W-1){1'b0}}, rvalid}, 0);
    chk("R1 dut_in", BUS_W'(dut_in), 0);
    rst = 0;
    idle();
    for (int k = 0; k < N_STAT; k++) rd(SBASE + k, "R1 status");
    rd(OBASE + 2, "R1 out reg");
  endtask

  task automatic t_inputs();
    wr(1, 16'hFABC);
    chk("R2 dut_in port1", BUS_W'(dut_in[PORT_W +: PORT_W]), 16'h0ABC);
    wr(3, 16'h0123);
    chk("R2 dut_in port3", BUS_W'(dut_in[3*PORT_W +: PORT_W]), 16'h0123);
    rd(1, "R3 readback 1");
    rd(3, "R3 readback 3");
    rd(0, "R3 readback 0");
  endtask

  task automatic t_single_change();
    set_out(3, 12'h5A5);
    idle();
    rd(SBASE, "R5 status bit3 set");
    chk("R5 bit3 value", rdata & 16'h0008, 16'h0008);
    rd(OBASE + 3, "R4 captured port3");
    chk("R4 value", rdata, 16'h05A5);
    rd(SBASE, "R6 cleared after read");
    chk("R6 bit3 clear", rdata & 16'h0008, 0);
  endtask

  task automatic t_persist();
    set_out(7, 12'h111);
    idle();
    set_out(7, 12'h222);
    idle(); idle();
    rd(0, "R6 other region read");
    rd(SBASE, "R6 flag held");
    chk("R6 bit7 held", rdata & 16'h0080, 16'h0080);
    rd(OBASE + 7, "R4 latest port7");
    chk("R4 port7 value", rdata, 16'h0222);
    rd(SBASE, "R6 bit7 cleared");
  endtask

  task automatic t_set_wins();
    logic [BUS_W-1:0] e;
    set_out(5, 12'h0AA);
    idle();
    rd(OBASE + 5, "R6 clear port5");
    set_out(5, 12'h0BB);
    rd_en = 1; addr = ADDR_W'(OBASE + 5);
    tick(e);
    rd_en = 0;
    chk("R7 read returns old value", rdata, 16'h00AA);
    rd(SBASE, "R7 flag after collision");
    chk("R7 bit5 set", rdata & 16'h0020, 16'h0020);
    rd(OBASE + 5, "R7 new value");
    chk("R7 port5 value", rdata, 16'h00BB);
  endtask

  task automatic t_mapping();
    set_out(17, 12'h777);
    set_out(19, 12'h001);
    idle();
    rd(SBASE + 1, "R8 word1");
    chk("R8 word1 bits", rdata, 16'h000A);
    rd(SBASE, "R8 word0 untouched");
    rd(OBASE + 17, "R8 fetch 17");
    rd(OBASE + 19, "R8 fetch 19");
    rd(SBASE + 1, "R8 word1 cleared");
    chk("R8 word1 zero", rdata, 0);
  endtask

  task automatic t_stray_writes();
    set_out(9, 12'h0C3);
    idle();
    wr(OBASE + 9, 16'h0FFF);
    wr(SBASE, 16'h0000);
    wr(SBASE + 1, 16'hFFFF);
    rd(SBASE, "R9 status unchanged");
    chk("R9 bit9 still set", rdata & 16'h0200, 16'h0200);
    rd(SBASE + 1, "R9 word1 unchanged");
    rd(OBASE + 9, "R9 out reg unchanged");
    chk("R9 port9 value", rdata, 16'h00C3);
    for (int j = 0; j < N_IN; j++) rd(j, "R9 inputs unchanged");
  endtask

  task automatic t_unmapped();
    rd(N_TOT, "R10 unmapped low");
    chk("R10 unmapped zero", rdata, 0);
    rd((1 << ADDR_W) - 1, "R10 unmapped top");
    idle();
    chk("R10 rvalid drops", {{(BUS_W-1){1'b0}}, rvalid}, 0);
  endtask

  task automatic t_random();
    for (int it = 0; it < 150; it++) begin
      for (int p = 0; p < N_OUT; p++)
        if ($urandom_range(0, 3) == 0) set_out(p, PORT_W'($urandom));
      idle();
      for (int k = 0; k < N_STAT; k++) rd(SBASE + k, "R8 random status");
      for (int p = 0; p < N_OUT; p++)
        if (exp_flag[p]) rd(OBASE + p, "R4 random fetch");
      for (int k = 0; k < N_STAT; k++) rd(SBASE + k, "R6 random cleared");
    end
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_inputs();
    t_single_change();
    t_persist();
    t_set_wins();
    t_mapping();
    t_stray_writes();
    t_unmapped();
    t_random();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule